// File: doc/BRIEF.md
# Dual-Set Receive DMA Ring Controller

This block is the receive side of a network DMA channel. Frames arrive as a byte stream. Each accepted frame goes into the next fixed 2048-byte buffer of a ring in memory, through a byte-lane memory write port. Every buffer starts with a 4-byte header slot. Frame data begins 4 bytes in. When the frame ends, the block writes a 16-bit header at the start of the buffer. The header holds the stored byte count and a status byte with the error flags.

Two complete register sets are provided, and each holds a base address and a buffer count. Software arms one set. The block fills that set's buffers in order and counts the remaining ones down. It raises an interrupt after every stored frame. Software reads the remaining count, computes how many buffers are filled, and then acknowledges. When the last buffer of the active set is filled, that set disarms and the other set takes over, so software can reload and rearm the exhausted one while traffic continues.

Top module: `rx_ring_dma`

## Requirements
- R1: After rst_ni is released, irq_o is low, no memory write occurs, and every register reads 0.
- R2: Byte k (counting from 0) of a frame accepted into buffer i of a set is written with mem_be_o=01 and the byte in mem_wdata_o[7:0], to address base+i*2048+4+k. The write appears in the cycle after that byte is presented.
- R3: One cycle after the slot of the final data byte, a write with mem_be_o=11 goes to base+i*2048. It carries the stored byte count bits [7:0] in mem_wdata_o[7:0] and a status byte in mem_wdata_o[15:8]. Status bits [3:0] hold count bits [11:8].
- R4: The length register of a set reads the buffers still remaining. Each stored frame decrements it by one. Each frame goes to buffer index = loaded length - remaining.
- R5: The data area of a buffer is 2044 bytes. Bytes beyond it are not written. The count is then 2044 and status bit 7 (overflow) is set.
- R6: rx_flags_i is sampled with the last byte: bit0 (FCS error) goes to status bit 4, bit1 (framing error) to status bit 5, and bit2 (collision) to status bit 6.
- R7: A stored frame sets its set's done flag (command readback bit 8; status bit 8 is the OR of both sets) and irq_o in the cycle the header is written. Both stay set until 0x0100 or 0x9800 is written to that set's command register. An acknowledge to the other set leaves them set.
- R8: When the remaining count of the active set reaches 0, that set disarms (command readback bit 15 clears). The other set becomes active (status bit 4 gives the active set index), and the next frame goes to the other set once it is armed.
- R9: If a frame's first byte arrives while the channel runs but the active set is unarmed or empty, the frame is dropped with no write. The error flag (status bit 13) and irq_o are then set, and they stay set until 0x8800 is written to the control register.
- R10: Writing 0x1100 to a set's command register disarms the set and leaves its remaining count unchanged. Writing 0x9800 arms it again, and filling resumes at the next unfilled buffer.
- R11: While the channel is off (after 0x1000) or held in reset (after 0x8800), frames are ignored with no write and no error. Writing 0x0400 to the control register releases the channel and enables it. Status bit 10 reads 1 while the channel runs, and status bit 0 reads 1 while it is held in reset.
- R12: Writing 0x8800 to the control register clears the armed flags, the done flags and the error flag, and selects set 0 as active. Base and length registers keep their values.
- R13: Register map in bytes on reg_addr_i: control/status at 0x00. Set 0 has its command at 0x20, base at 0x24 and length at 0x28. Set 1 uses the same layout at 0x30, 0x34 and 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the last byte of a frame |
| rx_flags_i | input | 3 | Frame error flags, sampled with the last byte |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 32 | Memory byte address |
| mem_be_o | output | 2 | Byte lane enables |
| mem_wdata_o | output | 16 | Memory write data |
| irq_o | output | 1 | Interrupt, level |

## Verification
A data byte's write is due one cycle after the byte is presented. The header write, the decremented length, the done flag and irq_o are all due two cycles after the last byte. The bench drives inputs on the falling edge and samples on the next falling edge. For one single-byte frame, it checks the data write and then the header write and interrupt in those exact cycles. For the other frames, a falling-edge monitor records every write into a byte-addressed model. Buffer contents, headers, write counts and register readback are compared only after several idle cycles, when all results are due. Frames are always separated by at least one idle cycle, as the header slot requires.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam logic [15:0] CMD_ARM  = 16'h9800;
  localparam logic [15:0] CMD_STOP = 16'h1100;
  localparam logic [15:0] CMD_ACK  = 16'h0100;
  localparam logic [15:0] CTL_RST  = 16'h8800;
  localparam logic [15:0] CTL_EN   = 16'h0400;
  localparam logic [15:0] CTL_OFF  = 16'h1000;

  localparam logic [5:0] REG_CTL = 6'h00;

  // field select within a set, reg_addr_i[3:0]
  localparam logic [3:0] FLD_CMD  = 4'h0;
  localparam logic [3:0] FLD_BASE = 4'h4;
  localparam logic [3:0] FLD_LEN  = 4'h8;

  localparam int unsigned ST_ERR_BIT  = 13;
  localparam int unsigned ST_RUN_BIT  = 10;
  localparam int unsigned ST_DONE_BIT = 8;
  localparam int unsigned ST_ACT_BIT  = 4;
  localparam int unsigned CMD_ARMED_BIT = 15;

  typedef enum logic [1:0] {
    W_IDLE,
    W_RECV,
    W_SKIP,
    W_HDR
  } wr_state_e;
endpackage

// File: rtl/rx_ring_regs.sv
module rx_ring_regs
  import rx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BUF_BYTES = 2048
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          frame_done_i,
  input  logic          frame_set_i,
  input  logic          drop_i,
  output logic          run_o,
  output logic          act_set_o,
  output logic          act_ok_o,
  output logic [AW-1:0] act_buf_o,
  output logic          err_o,
  output logic          irq_o
);
  localparam int unsigned NSETS  = 2;
  localparam int unsigned BUF_LG = $clog2(BUF_BYTES);

  logic [AW-1:0]    base_q  [NSETS];
  logic [LEN_W-1:0] total_q [NSETS];
  logic [LEN_W-1:0] left_q  [NSETS];
  logic [NSETS-1:0] armed_q, done_q;
  logic en_q, inrst_q, err_q, act_q;

  logic ctl_wr, ctl_rst;
  assign ctl_wr  = reg_we_i && (reg_addr_i == REG_CTL);
  assign ctl_rst = ctl_wr && (reg_wdata_i[15:0] == CTL_RST);

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic hit, cmd_wr, base_wr, len_wr, fd_here;
    assign hit     = reg_we_i && reg_addr_i[5] && (reg_addr_i[4] == 1'(s));
    assign cmd_wr  = hit && (reg_addr_i[3:0] == FLD_CMD);
    assign base_wr = hit && (reg_addr_i[3:0] == FLD_BASE);
    assign len_wr  = hit && (reg_addr_i[3:0] == FLD_LEN);
    assign fd_here = frame_done_i && (frame_set_i == 1'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[s]  <= '0;
        total_q[s] <= '0;
        left_q[s]  <= '0;
        armed_q[s] <= 1'b0;
        done_q[s]  <= 1'b0;
      end else begin
        if (fd_here) begin
          left_q[s] <= left_q[s] - LEN_W'(1);
          if (left_q[s] == LEN_W'(1)) armed_q[s] <= 1'b0;
        end
        if (ctl_rst) begin
          armed_q[s] <= 1'b0;
          done_q[s]  <= 1'b0;
        end else begin
          if (fd_here) done_q[s] <= 1'b1;
          if (cmd_wr) begin
            unique case (reg_wdata_i[15:0])
              CMD_ARM:  begin armed_q[s] <= 1'b1; done_q[s] <= 1'b0; end
              CMD_STOP: armed_q[s] <= 1'b0;
              CMD_ACK:  done_q[s]  <= 1'b0;
              default:  ;
            endcase
          end
        end
        if (base_wr) base_q[s] <= reg_wdata_i[AW-1:0];
        if (len_wr) begin
          total_q[s] <= reg_wdata_i[LEN_W-1:0];
          left_q[s]  <= reg_wdata_i[LEN_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      inrst_q <= 1'b0;
      err_q   <= 1'b0;
      act_q   <= 1'b0;
    end else if (ctl_rst) begin
      en_q    <= 1'b0;
      inrst_q <= 1'b1;
      err_q   <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      if (ctl_wr && reg_wdata_i[15:0] == CTL_EN) begin
        inrst_q <= 1'b0;
        en_q    <= 1'b1;
      end else if (ctl_wr && reg_wdata_i[15:0] == CTL_OFF) begin
        en_q <= 1'b0;
      end
      if (drop_i) err_q <= 1'b1;
      // hand off once the set that took this frame runs dry
      if (frame_done_i && left_q[frame_set_i] == LEN_W'(1)) act_q <= ~frame_set_i;
    end
  end

  logic [LEN_W-1:0] act_idx;
  assign act_idx   = total_q[act_q] - left_q[act_q];
  assign act_buf_o = base_q[act_q] + (AW'(act_idx) << BUF_LG);
  assign act_ok_o  = armed_q[act_q] && (left_q[act_q] != '0);
  assign act_set_o = act_q;
  assign run_o     = en_q && !inrst_q;
  assign err_o     = err_q;
  assign irq_o     = (|done_q) || err_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_CTL) begin
      reg_rdata_o[ST_ERR_BIT]  = err_q;
      reg_rdata_o[ST_RUN_BIT]  = run_o;
      reg_rdata_o[ST_DONE_BIT] = |done_q;
      reg_rdata_o[ST_ACT_BIT]  = act_q;
      reg_rdata_o[0]           = inrst_q;
    end else if (reg_addr_i[5]) begin
      unique case (reg_addr_i[3:0])
        FLD_CMD: begin
          reg_rdata_o[CMD_ARMED_BIT] = armed_q[reg_addr_i[4]];
          reg_rdata_o[ST_DONE_BIT]   = done_q[reg_addr_i[4]];
        end
        FLD_BASE: reg_rdata_o = 32'(base_q[reg_addr_i[4]]);
        FLD_LEN:  reg_rdata_o = 32'(left_q[reg_addr_i[4]]);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rx_ring_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned HDR_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          act_ok_i,
  input  logic          act_set_i,
  input  logic [AW-1:0] act_buf_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  input  logic [2:0]    rx_flags_i,
  output logic          frame_done_o,
  output logic          frame_set_o,
  output logic          drop_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o
);
  localparam int unsigned CNT_W = 12;  // header holds a 12-bit count
  localparam int unsigned CAP   = BUF_BYTES - HDR_BYTES;

  wr_state_e        state_q;
  logic [AW-1:0]    buf_q;
  logic             set_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [2:0]       flags_q;

  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    be_q;
  logic [15:0]   wdata_q;

  assign frame_done_o = (state_q == W_HDR) && run_i;
  assign frame_set_o  = set_q;
  assign drop_o       = (state_q == W_IDLE) && rx_valid_i && run_i && !act_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      buf_q   <= '0;
      set_q   <= 1'b0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      flags_q <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      unique case (state_q)
        W_IDLE: begin
          if (rx_valid_i && run_i) begin
            if (act_ok_i) begin
              buf_q   <= act_buf_i;
              set_q   <= act_set_i;
              cnt_q   <= CNT_W'(1);
              ovf_q   <= 1'b0;
              we_q    <= 1'b1;
              be_q    <= 2'b01;
              addr_q  <= act_buf_i + AW'(HDR_BYTES);
              wdata_q <= {8'h00, rx_data_i};
              if (rx_last_i) begin
                flags_q <= rx_flags_i;
                state_q <= W_HDR;
              end else begin
                state_q <= W_RECV;
              end
            end else if (!rx_last_i) begin
              state_q <= W_SKIP;
            end
          end
        end
        W_RECV: begin
          if (!run_i) begin
            state_q <= W_IDLE;
          end else if (rx_valid_i) begin
            if (cnt_q < CNT_W'(CAP)) begin
              we_q    <= 1'b1;
              be_q    <= 2'b01;
              addr_q  <= buf_q + AW'(HDR_BYTES) + AW'(cnt_q);
              wdata_q <= {8'h00, rx_data_i};
              cnt_q   <= cnt_q + CNT_W'(1);
            end else begin
              ovf_q <= 1'b1;
            end
            if (rx_last_i) begin
              flags_q <= rx_flags_i;
              state_q <= W_HDR;
            end
          end
        end
        W_SKIP: begin
          if (!run_i || (rx_valid_i && rx_last_i)) state_q <= W_IDLE;
        end
        W_HDR: begin
          state_q <= W_IDLE;
          if (run_i) begin
            we_q    <= 1'b1;
            be_q    <= 2'b11;
            addr_q  <= buf_q;
            wdata_q <= {ovf_q, flags_q, cnt_q[11:8], cnt_q[7:0]};
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_be_o    = be_q;
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma #(
  parameter int unsigned AW        = 32,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned HDR_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [5:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_last_i,
  input  logic [2:0]    rx_flags_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_be_o,
  output logic [15:0]   mem_wdata_o,
  output logic          irq_o
);
  logic          run_w, act_ok_w, act_set_w;
  logic [AW-1:0] act_buf_w;
  logic          frame_done_w, frame_set_w, drop_w, err_w;

  rx_ring_regs #(
    .AW(AW), .LEN_W(LEN_W), .BUF_BYTES(BUF_BYTES)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_we_i     (reg_we_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .reg_rdata_o  (reg_rdata_o),
    .frame_done_i (frame_done_w),
    .frame_set_i  (frame_set_w),
    .drop_i       (drop_w),
    .run_o        (run_w),
    .act_set_o    (act_set_w),
    .act_ok_o     (act_ok_w),
    .act_buf_o    (act_buf_w),
    .err_o        (err_w),
    .irq_o        (irq_o)
  );

  rx_ring_writer #(
    .AW(AW), .BUF_BYTES(BUF_BYTES), .HDR_BYTES(HDR_BYTES)
  ) u_writer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run_w),
    .act_ok_i     (act_ok_w),
    .act_set_i    (act_set_w),
    .act_buf_i    (act_buf_w),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .rx_last_i    (rx_last_i),
    .rx_flags_i   (rx_flags_i),
    .frame_done_o (frame_done_w),
    .frame_set_o  (frame_set_w),
    .drop_o       (drop_w),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o)
  );
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [5:0]  reg_addr_i,
  input logic [31:0] reg_wdata_i,
  input logic        mem_we_o,
  input logic [1:0]  mem_be_o,
  input logic        irq_o,
  input logic        run_w,
  input logic        frame_done_w,
  input logic        drop_w,
  input logic        err_w
);
  logic clr_wr;
  assign clr_wr = reg_we_i && (reg_wdata_i[15:0] == 16'h0100 ||
                               reg_wdata_i[15:0] == 16'h9800 ||
                               reg_wdata_i[15:0] == 16'h8800);

  a_r11_write_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(run_w));

  a_r3_lanes_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_be_o == 2'b01 || mem_be_o == 2'b11));

  a_r7_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(frame_done_w || drop_w));

  a_r7_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr) |=> irq_o);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_w && !(reg_we_i && reg_addr_i == 6'h00 && reg_wdata_i[15:0] == 16'h8800)) |=> err_w);

  a_r9_drop_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_w |=> !mem_we_o);
endmodule

bind rx_ring_dma rx_ring_dma_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .mem_we_o     (mem_we_o),
  .mem_be_o     (mem_be_o),
  .irq_o        (irq_o),
  .run_w        (run_w),
  .frame_done_w (frame_done_w),
  .drop_w       (drop_w),
  .err_w        (err_w)
);

// File: tb/rx_ring_dma_tb_top.sv
`timescale 1ns/1ps
module rx_ring_dma_tb_top;
  localparam logic [31:0] B0 = 32'h1000_0000;
  localparam logic [31:0] B1 = 32'h2000_0000;
  localparam int CAP = 2044;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_last = 1'b0;
  logic [2:0]  rx_flags = '0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int wr_cnt = 0;
  int cyc = 0;
  logic [7:0] mem_model [logic [31:0]];
  logic [7:0] pay [0:2099];

  always #2.5 clk = ~clk;

  rx_ring_dma dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last), .rx_flags_i(rx_flags),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be), .mem_wdata_o(mem_wdata),
    .irq_o(irq)
  );

  always @(negedge clk) begin
    if (mem_we) begin
      mem_model[mem_addr] = mem_wdata[7:0];
      if (mem_be == 2'b11) mem_model[mem_addr + 32'd1] = mem_wdata[15:8];
      wr_cnt++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic gen_pay(input int len);
    for (int i = 0; i < len; i++) pay[i] = 8'($urandom);
  endtask

  task automatic send_frame(input int len, input logic [2:0] fl);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pay[i]; rx_last = (i == len - 1); rx_flags = fl;
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_status(input int stored, input logic [2:0] fl, input logic ovf);
    logic [11:0] s;
    s = 12'(stored);
    return {ovf, fl, s[11:8]};
  endfunction

  task automatic check_frame(input string tag, input logic [31:0] b, input int len,
                             input logic [2:0] fl, input int w0);
    int stored;
    int bad;
    stored = (len > CAP) ? CAP : len;
    bad = 0;
    for (int i = 0; i < stored; i++)
      if (mem_model[b + 32'd4 + 32'(i)] !== pay[i]) bad++;
    check({tag, " data bytes (R2)"}, 32'(bad), 32'd0);
    check({tag, " header count (R3)"}, 32'(mem_model[b]), 32'(stored & 8'hff));
    check({tag, " header status (R3/R6)"}, 32'(mem_model[b + 32'd1]),
          32'(exp_status(stored, fl, len > CAP)));
    check({tag, " write count (R2)"}, 32'(wr_cnt - w0), 32'(stored + 1));
  endtask

  task automatic ack(input logic [5:0] cmd_a);
    reg_wr(cmd_a, 32'h0100);
  endtask

  initial begin
    logic [31:0] d;
    int w0;
    int len;
    logic [2:0] fl;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 32'd0);
    reg_rd(6'h00, d); check("R1 status", d, 32'd0);
    reg_rd(6'h20, d); check("R1 set0 cmd", d, 32'd0);
    reg_rd(6'h34, d); check("R1 set1 base", d, 32'd0);
    reg_rd(6'h28, d); check("R1 set0 len", d, 32'd0);
    check("R1 no writes", 32'(wr_cnt), 32'd0);

    // R13 register map
    reg_wr(6'h24, B0); reg_wr(6'h28, 32'd8);
    reg_wr(6'h34, B1); reg_wr(6'h38, 32'd8);
    reg_rd(6'h24, d); check("R13 set0 base", d, B0);
    reg_rd(6'h38, d); check("R13 set1 len", d, 32'd8);
    reg_wr(6'h00, 32'h0400);
    reg_rd(6'h00, d); check("R11 running", d, 32'h0000_0400);
    reg_wr(6'h20, 32'h9800);
    reg_rd(6'h20, d); check("R10 armed", d, 32'h0000_8000);

    // R2/R3/R7 cycle timing with a one-byte frame
    pay[0] = 8'h5a;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5a; rx_last = 1'b1; rx_flags = 3'b000;
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    check("R2 data we", 32'(mem_we), 32'd1);
    check("R2 data addr", mem_addr, B0 + 32'd4);
    check("R2 data lanes", 32'(mem_be), 32'd1);
    check("R7 irq not yet", 32'(irq), 32'd0);
    @(negedge clk);
    check("R3 hdr we", 32'(mem_we), 32'd1);
    check("R3 hdr addr", mem_addr, B0);
    check("R3 hdr lanes", 32'(mem_be), 32'd3);
    check("R3 hdr word", 32'(mem_wdata), 32'h0001);
    check("R7 irq", 32'(irq), 32'd1);
    repeat (3) @(negedge clk);
    reg_rd(6'h28, d); check("R4 left after 1", d, 32'd7);
    reg_rd(6'h20, d); check("R7 done readback", d, 32'h0000_8100);
    ack(6'h30);
    check("R7 other-set ack keeps irq", 32'(irq), 32'd1);
    ack(6'h20);
    check("R7 ack clears irq", 32'(irq), 32'd0);

    // random frames, buffers 1..5
    for (int k = 1; k <= 5; k++) begin
      len = 1 + int'($urandom % 80);
      fl = 3'($urandom);
      gen_pay(len);
      w0 = wr_cnt;
      send_frame(len, fl);
      check_frame($sformatf("rand%0d", k), B0 + 32'(k) * 32'd2048, len, fl, w0);
      reg_rd(6'h28, d); check("R4 left", d, 32'(8 - 1 - k));
      check("R7 irq after frame", 32'(irq), 32'd1);
      ack(6'h20);
    end

    // R5 truncation, buffer 6
    gen_pay(2050);
    w0 = wr_cnt;
    send_frame(2050, 3'b001);
    check_frame("R5 long", B0 + 32'd6 * 32'd2048, 2050, 3'b001, w0);
    check("R5 beyond cap unwritten", 32'(mem_model.exists(B0 + 32'd6 * 32'd2048 + 32'd4 + 32'(CAP))), 32'd0);
    ack(6'h20);

    // R10 stop keeps count, rearm resumes at buffer 7
    reg_wr(6'h20, 32'h1100);
    reg_rd(6'h28, d); check("R10 stop keeps left", d, 32'd1);
    reg_rd(6'h20, d); check("R10 stop disarms", d, 32'd0);
    reg_wr(6'h20, 32'h9800);
    len = 20; fl = 3'b110; gen_pay(len); w0 = wr_cnt;
    send_frame(len, fl);
    check_frame("R10 resume", B0 + 32'd7 * 32'd2048, len, fl, w0);
    reg_rd(6'h28, d); check("R4 left zero", d, 32'd0);
    reg_rd(6'h20, d); check("R8 set0 disarmed", d & 32'h8000, 32'd0);
    reg_rd(6'h00, d); check("R8 active set1", d & 32'h10, 32'h10);
    ack(6'h20);

    // R8 set1 takes the next frame
    reg_wr(6'h30, 32'h9800);
    len = 33; fl = 3'b010; gen_pay(len); w0 = wr_cnt;
    send_frame(len, fl);
    check_frame("R8 set1", B1, len, fl, w0);
    ack(6'h30);

    // R9 drop while active set unarmed
    reg_wr(6'h30, 32'h1100);
    len = 10; gen_pay(len); w0 = wr_cnt;
    send_frame(len, 3'b000);
    check("R9 no write on drop", 32'(wr_cnt - w0), 32'd0);
    reg_rd(6'h00, d); check("R9 err flag", d & 32'h2000, 32'h2000);
    check("R9 irq", 32'(irq), 32'd1);
    reg_wr(6'h30, 32'h9800);
    reg_rd(6'h00, d); check("R9 err sticky", d & 32'h2000, 32'h2000);

    // R12 channel reset
    reg_wr(6'h00, 32'h8800);
    reg_rd(6'h00, d); check("R12 status after reset", d, 32'h0000_0001);
    check("R12 irq cleared", 32'(irq), 32'd0);
    reg_rd(6'h34, d); check("R12 base kept", d, B1);
    reg_rd(6'h38, d); check("R12 len kept", d, 32'd7);
    reg_rd(6'h30, d); check("R12 disarmed", d, 32'd0);
    w0 = wr_cnt;
    send_frame(5, 3'b000);
    check("R11 ignored in reset", 32'(wr_cnt - w0), 32'd0);

    // R11 release, then channel off
    reg_wr(6'h00, 32'h0400);
    reg_wr(6'h28, 32'd8);
    reg_wr(6'h20, 32'h9800);
    len = 12; fl = 3'b100; gen_pay(len); w0 = wr_cnt;
    send_frame(len, fl);
    check_frame("R12 set0 active", B0, len, fl, w0);
    ack(6'h20);
    reg_wr(6'h00, 32'h1000);
    w0 = wr_cnt;
    send_frame(6, 3'b000);
    check("R11 off no write", 32'(wr_cnt - w0), 32'd0);
    reg_rd(6'h00, d); check("R11 off no error", d, 32'd0);
    check("R11 off irq low", 32'(irq), 32'd0);
    reg_wr(6'h00, 32'h0400);
    len = 40; fl = 3'b011; gen_pay(len); w0 = wr_cnt;
    send_frame(len, fl);
    check_frame("R11 re-enabled", B0 + 32'd2048, len, fl, w0);

    summary();
  end
endmodule